// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the host-facing register window of a single descriptor-driven DMA channel on a 32-bit register bus. Software steers the channel by writing a control word whose upper half is a bit mask and whose lower half carries the new bit values. The block turns each such write into an updated channel status: run, pause, flush, wake, dead, active and branch-taken, plus four device condition bits. It also holds the descriptor pointer and three condition-select words (interrupt, branch and wait) that the descriptor sequencer consumes.

Toward the rest of the channel it offers a flush request with acknowledge to the data engine, a one-cycle kick to the sequencer whenever a control write leaves the channel active, and a one-cycle fetch request whenever software loads a new descriptor pointer. The sequencer reports its own effects (stop, kill, wake consumed, branch taken or not, pointer advance) on dedicated pulse inputs, so descriptor execution itself stays outside.

The bus uses a valid/ready handshake. Reads are always taken and answer one cycle later on `rd_valid`/`rd_data`. Writes are held off (ready low) while a flush is outstanding, because the status that the write would build on is not yet final. Accesses whose channel field does not match `CHAN_ID` are ignored and produce no read response.

Top module: `dmac_chan_regs`

## Requirements
- R1: After reset every readable word is zero, and `flush_req`, `kick` and `fetch_req` are low.
- R2: A control write with mask bit 15 and value bit 15 set sets RUN (status bit 15) and ACTIVE (bit 10) and pulses `kick` for one cycle; value bits whose mask bit is clear change nothing and request no flush.
- R3: A control write with mask bit 15 set and value bit 15 clear requests a flush; once `flush_ack` arrives, RUN, DEAD (bit 11) and ACTIVE are clear, and until then the status keeps its old value.
- R4: A masked write of WAKE (bit 12) as 1 sets WAKE and ACTIVE only while RUN is set; with RUN clear, WAKE stays clear and a flush is requested.
- R5: PAUSE (bit 14) takes the written value when masked in; PAUSE set clears ACTIVE after a flush, and clearing PAUSE with RUN set sets ACTIVE and pulses `kick`.
- R6: A masked write of FLUSH (bit 13) as 1 raises `flush_req` until `flush_ack`; FLUSH reads as 1 only during that time, writes are refused (bus_ready low) meanwhile, and FLUSH reads 0 after the commit.
- R7: Reading the control word (word 0) returns the same value as the status word (word 1).
- R8: Writes to the pointer word (word 2) are dropped while ACTIVE is set; an accepted write stores the data with bits 3:0 cleared and pulses `fetch_req`.
- R9: The interrupt, branch and wait select words (words 3, 4, 5) read back exactly what was written; all other words (6 to 15) read zero and ignore writes.
- R10: Only 32-bit aligned accesses (all four byte enables, address bits 1:0 zero) take effect; other writes are dropped and other reads return zero.
- R11: The channel is selected by address bits above bit 5 equal to `CHAN_ID`; accesses to any other channel change nothing and give no `rd_valid`.
- R12: `seq_kill` sets DEAD and clears ACTIVE, `seq_stop` clears ACTIVE, `seq_wake_clr` clears WAKE, `seq_bt_set`/`seq_bt_clr` set/clear branch-taken (bit 8), and status bits 3:0 follow `dev_status` one cycle late.
- R13: `seq_ptr_we` loads `seq_ptr` into the pointer with bits 3:0 cleared, regardless of ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted this cycle |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| dev_status | input | 4 | Device condition bits |
| seq_kill | input | 1 | Sequencer: channel dead |
| seq_stop | input | 1 | Sequencer: stop reached |
| seq_wake_clr | input | 1 | Sequencer: wake consumed at fetch |
| seq_bt_set | input | 1 | Sequencer: branch taken |
| seq_bt_clr | input | 1 | Sequencer: sequential advance |
| seq_ptr_we | input | 1 | Sequencer: load pointer |
| seq_ptr | input | 32 | Sequencer: new pointer |
| flush_req | output | 1 | Flush request to data engine |
| flush_ack | input | 1 | Flush finished |
| kick | output | 1 | Start pulse to sequencer |
| fetch_req | output | 1 | Descriptor fetch pulse |
| status_out | output | 32 | Live channel status |
| cmd_ptr | output | 32 | Descriptor pointer |
| intr_sel | output | 32 | Interrupt condition select |
| branch_sel | output | 32 | Branch condition select |
| wait_sel | output | 32 | Wait condition select |

## Verification
The hardest state to reach is the window in which a flush is outstanding: the old status is still live, FLUSH may be showing, and writes are refused. The bench holds `flush_ack` low on purpose, reads the control word inside that window, tries a write to confirm back-pressure, and only then acknowledges. Reaching the dead-but-running state needed for the wake checks also requires the sequencer kill input, since software alone cannot set DEAD.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int DW = 32;
  localparam int NUM_SEL = 3;

  // status bit positions
  localparam int ST_RUN    = 15;
  localparam int ST_PAUSE  = 14;
  localparam int ST_FLUSH  = 13;
  localparam int ST_WAKE   = 12;
  localparam int ST_DEAD   = 11;
  localparam int ST_ACTIVE = 10;
  localparam int ST_BT     = 8;
  localparam int MASK_OFS  = 16;

  // word indices in the channel window
  localparam int W_CTRL = 0;
  localparam int W_STAT = 1;
  localparam int W_CPTR = 2;
  localparam int W_SEL0 = 3;

  typedef struct packed {
    logic kill;
    logic stop;
    logic wake_clr;
    logic bt_set;
    logic bt_clr;
  } seq_ev_t;

  typedef struct packed {
    logic [DW-1:0] st;
    logic          flush;
    logic          flush_bit;
  } ctl_res_t;

  function automatic ctl_res_t ctl_merge(input logic [DW-1:0] cur, input logic [DW-1:0] wr);
    ctl_res_t r;
    logic [DW-1:0] n;
    n = cur;
    n[ST_FLUSH] = 1'b0;
    if (wr[MASK_OFS+ST_RUN]) begin
      if (wr[ST_RUN]) n[ST_RUN] = 1'b1;
      else begin
        n[ST_RUN]  = 1'b0;
        n[ST_DEAD] = 1'b0;
      end
    end
    if (wr[MASK_OFS+ST_WAKE] && wr[ST_WAKE] && n[ST_RUN]) n[ST_WAKE] = 1'b1;
    if (wr[MASK_OFS+ST_PAUSE]) n[ST_PAUSE] = wr[ST_PAUSE];
    r.flush_bit = wr[MASK_OFS+ST_FLUSH] & wr[ST_FLUSH];
    r.flush     = r.flush_bit;
    if (n[ST_PAUSE] || !n[ST_RUN]) begin
      n[ST_ACTIVE] = 1'b0;
      r.flush      = 1'b1;
    end else if (wr[MASK_OFS+ST_RUN] || wr[MASK_OFS+ST_PAUSE] ||
                 (wr[MASK_OFS+ST_WAKE] && wr[ST_WAKE])) begin
      n[ST_ACTIVE] = 1'b1;
    end
    r.st = n;
    return r;
  endfunction

  function automatic logic [DW-1:0] apply_seq(input logic [DW-1:0] st, input seq_ev_t ev,
                                               input logic [3:0] dev);
    logic [DW-1:0] n;
    n = st;
    if (ev.kill) begin
      n[ST_DEAD]   = 1'b1;
      n[ST_ACTIVE] = 1'b0;
    end
    if (ev.stop) n[ST_ACTIVE] = 1'b0;
    if (ev.wake_clr) n[ST_WAKE] = 1'b0;
    if (ev.bt_set) n[ST_BT] = 1'b1;
    if (ev.bt_clr) n[ST_BT] = 1'b0;
    n[3:0] = dev;
    return n;
  endfunction
endpackage

// File: rtl/dmac_bus_decode.sv
module dmac_bus_decode #(
  parameter int ADDR_W    = 12,
  parameter int CHAN_ID   = 3,
  parameter int REG_WORDS = 16
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic              flush_busy,
  output logic              bus_ready,
  output logic              wr_ok,
  output logic              rd_hit,
  output logic              rd_ok,
  output logic [$clog2(REG_WORDS)-1:0] word_idx
);
  localparam int IDX_W  = $clog2(REG_WORDS);
  localparam int WIN_W  = IDX_W + 2;
  localparam int CHAN_W = ADDR_W - WIN_W;

  logic sel, full_word;

  assign sel       = (bus_addr[ADDR_W-1:WIN_W] == CHAN_W'(CHAN_ID));
  assign full_word = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  assign word_idx  = bus_addr[WIN_W-1:2];
  assign bus_ready = !(bus_write && flush_busy);
  assign wr_ok     = bus_valid && bus_write && bus_ready && sel && full_word;
  assign rd_hit    = bus_valid && !bus_write && sel;
  assign rd_ok     = full_word;
endmodule

// File: rtl/dmac_status_ctl.sv
module dmac_status_ctl
  import dmac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [DW-1:0] ctl_wdata,
  input  seq_ev_t       ev,
  input  logic [3:0]    dev_status,
  input  logic          flush_ack,
  output logic [DW-1:0] status,
  output logic          flush_busy,
  output logic          kick
);
  ctl_res_t      merged;
  logic [DW-1:0] pend;
  logic [DW-1:0] pend_nx;
  logic [DW-1:0] live_nx;
  logic [DW-1:0] wr_nx;

  always_comb begin
    merged  = ctl_merge(status, ctl_wdata);
    pend_nx = apply_seq(pend, ev, dev_status);
    live_nx = apply_seq(status, ev, dev_status);
    wr_nx   = apply_seq(merged.st, ev, dev_status);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status     <= '0;
      pend       <= '0;
      flush_busy <= 1'b0;
      kick       <= 1'b0;
    end else begin
      kick <= 1'b0;
      if (flush_busy) begin
        if (flush_ack) begin
          status     <= pend_nx;
          flush_busy <= 1'b0;
          kick       <= pend_nx[ST_ACTIVE];
        end else begin
          status <= live_nx;
          pend   <= pend_nx;
        end
      end else if (ctl_we) begin
        if (merged.flush) begin
          pend       <= wr_nx;
          flush_busy <= 1'b1;
          status     <= live_nx | (DW'(merged.flush_bit) << ST_FLUSH);
        end else begin
          status <= wr_nx;
          kick   <= wr_nx[ST_ACTIVE];
        end
      end else begin
        status <= live_nx;
      end
    end
  end
endmodule

// File: rtl/dmac_cmd_regs.sv
module dmac_cmd_regs
  import dmac_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_ok,
  input  logic [IDX_W-1:0]          word_idx,
  input  logic [DW-1:0]             wdata,
  input  logic                      chan_active,
  input  logic                      seq_ptr_we,
  input  logic [DW-1:0]             seq_ptr,
  output logic [DW-1:0]             cmd_ptr,
  output logic                      fetch_req,
  output logic [NUM_SEL-1:0][DW-1:0] sel_q
);
  localparam logic [3:0] ALIGN_MASK = 4'h0;
  logic ptr_wr;

  assign ptr_wr = wr_ok && (word_idx == IDX_W'(W_CPTR)) && !chan_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ptr   <= '0;
      fetch_req <= 1'b0;
    end else begin
      fetch_req <= ptr_wr;
      if (ptr_wr) cmd_ptr <= {wdata[DW-1:4], ALIGN_MASK};
      else if (seq_ptr_we) cmd_ptr <= {seq_ptr[DW-1:4], ALIGN_MASK};
    end
  end

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n) sel_q[i] <= '0;
      else if (wr_ok && (word_idx == IDX_W'(W_SEL0 + i))) sel_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CHAN_ID   = 3,
  parameter int REG_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [3:0]        dev_status,
  input  logic              seq_kill,
  input  logic              seq_stop,
  input  logic              seq_wake_clr,
  input  logic              seq_bt_set,
  input  logic              seq_bt_clr,
  input  logic              seq_ptr_we,
  input  logic [31:0]       seq_ptr,
  output logic              flush_req,
  input  logic              flush_ack,
  output logic              kick,
  output logic              fetch_req,
  output logic [31:0]       status_out,
  output logic [31:0]       cmd_ptr,
  output logic [31:0]       intr_sel,
  output logic [31:0]       branch_sel,
  output logic [31:0]       wait_sel
);
  localparam int IDX_W = $clog2(REG_WORDS);

  logic                       wr_ok, rd_hit, rd_ok, flush_busy;
  logic [IDX_W-1:0]           word_idx;
  logic [NUM_SEL-1:0][DW-1:0] sel_q;
  logic [DW-1:0]              rd_mux;
  seq_ev_t                    ev;

  assign ev = '{kill: seq_kill, stop: seq_stop, wake_clr: seq_wake_clr,
                bt_set: seq_bt_set, bt_clr: seq_bt_clr};

  dmac_bus_decode #(.ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID), .REG_WORDS(REG_WORDS)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .flush_busy(flush_busy),
    .bus_ready (bus_ready),
    .wr_ok     (wr_ok),
    .rd_hit    (rd_hit),
    .rd_ok     (rd_ok),
    .word_idx  (word_idx)
  );

  dmac_status_ctl u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (wr_ok && (word_idx == IDX_W'(W_CTRL))),
    .ctl_wdata (bus_wdata),
    .ev        (ev),
    .dev_status(dev_status),
    .flush_ack (flush_ack),
    .status    (status_out),
    .flush_busy(flush_busy),
    .kick      (kick)
  );

  dmac_cmd_regs #(.IDX_W(IDX_W)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ok      (wr_ok),
    .word_idx   (word_idx),
    .wdata      (bus_wdata),
    .chan_active(status_out[ST_ACTIVE]),
    .seq_ptr_we (seq_ptr_we),
    .seq_ptr    (seq_ptr),
    .cmd_ptr    (cmd_ptr),
    .fetch_req  (fetch_req),
    .sel_q      (sel_q)
  );

  assign flush_req  = flush_busy;
  assign intr_sel   = sel_q[0];
  assign branch_sel = sel_q[1];
  assign wait_sel   = sel_q[2];

  always_comb begin
    rd_mux = '0;
    if (word_idx == IDX_W'(W_CTRL) || word_idx == IDX_W'(W_STAT)) rd_mux = status_out;
    else if (word_idx == IDX_W'(W_CPTR)) rd_mux = cmd_ptr;
    else begin
      for (int i = 0; i < NUM_SEL; i++)
        if (word_idx == IDX_W'(W_SEL0 + i)) rd_mux = sel_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_hit;
      rd_data  <= (rd_hit && rd_ok) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/dmac_chan_regs_chk.sv
module dmac_chan_regs_chk #(
  parameter int ADDR_W  = 12,
  parameter int CHAN_ID = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       status_out,
  input logic [31:0]       cmd_ptr,
  input logic              flush_req,
  input logic              flush_ack,
  input logic              kick,
  input logic              seq_ptr_we
);
  localparam logic [ADDR_W-1:0] PTR_ADDR = ADDR_W'((CHAN_ID << 6) | 8);

  logic ptr_wr_seen;
  assign ptr_wr_seen = bus_valid && bus_write && bus_ready && (bus_be == 4'hF) &&
                       (bus_addr == PTR_ADDR);

  a_r6_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req);

  a_r6_flush_bit_window: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[13] |-> flush_req);

  a_r8_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_seen && status_out[10] && !seq_ptr_we |=> $stable(cmd_ptr));

  a_r8_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ptr[3:0] == 4'h0);

  a_r3_active_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[10] |-> status_out[15]);

  a_r5_pause_blocks_active: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[14] |-> !status_out[10]);

  a_r2_kick_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> status_out[10]);
endmodule

bind dmac_chan_regs dmac_chan_regs_chk #(.ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .status_out(status_out),
  .cmd_ptr   (cmd_ptr),
  .flush_req (flush_req),
  .flush_ack (flush_ack),
  .kick      (kick),
  .seq_ptr_we(seq_ptr_we)
);

// File: tb/dmac_chan_regs_test.sv
`timescale 1ns/1ps
module dmac_chan_regs_test;
  localparam logic [11:0] BASE = 12'h0C0;
  localparam logic [11:0] A_CTL = BASE + 12'h00, A_STA = BASE + 12'h04, A_PTR = BASE + 12'h08;
  localparam logic [11:0] A_ISEL = BASE + 12'h0C, A_BSEL = BASE + 12'h10, A_WSEL = BASE + 12'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, rd_valid;
  logic [31:0] rd_data;
  logic [3:0] dev_status = '0;
  logic seq_kill = 0, seq_stop = 0, seq_wake_clr = 0, seq_bt_set = 0, seq_bt_clr = 0, seq_ptr_we = 0;
  logic [31:0] seq_ptr = '0;
  logic flush_req, flush_ack = 0, kick, fetch_req;
  logic [31:0] status_out, cmd_ptr, intr_sel, branch_sel, wait_sel;

  int nchk = 0, nfail = 0;
  logic s_kick, s_fetch, s_flush, s_valid;
  logic [31:0] s_data;

  always #2 clk = ~clk;

  dmac_chan_regs uut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    s_kick = kick; s_fetch = fetch_req; s_flush = flush_req;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_be = be;
    @(posedge clk); #1;
    s_valid = rd_valid; s_data = rd_data;
    @(negedge clk);
    bus_valid = 0; bus_be = 4'hF;
  endtask

  task automatic ack();
    @(negedge clk); flush_ack = 1;
    @(posedge clk); #1; s_kick = kick;
    @(negedge clk); flush_ack = 0;
  endtask

  task automatic seq_pulse(input logic [4:0] code);
    @(negedge clk);
    {seq_kill, seq_stop, seq_wake_clr, seq_bt_set, seq_bt_clr} = code;
    @(negedge clk);
    {seq_kill, seq_stop, seq_wake_clr, seq_bt_set, seq_bt_clr} = '0;
  endtask

  task automatic t_reset();
    rd(A_STA); chk(s_data, 0, "R1 status after reset");
    rd(A_PTR); chk(s_data, 0, "R1 pointer after reset");
    chk({29'd0, flush_req, kick, fetch_req}, 0, "R1 outputs idle");
  endtask

  task automatic t_run();
    wr(A_CTL, 32'h8000_8000); chk(s_kick, 1, "R2 kick on run");
    rd(A_STA); chk(s_data, 32'h8400, "R2 run+active");
    rd(A_CTL); chk(s_data, 32'h8400, "R7 control reads status");
    wr(A_CTL, 32'h0000_FFFF); chk(s_flush, 0, "R2 unmasked no flush");
    rd(A_STA); chk(s_data, 32'h8400, "R2 unmasked values ignored");
  endtask

  task automatic t_ptr_lock();
    wr(A_PTR, 32'h1234_5678); chk(s_fetch, 0, "R8 no fetch while active");
    rd(A_PTR); chk(s_data, 0, "R8 pointer locked");
  endtask

  task automatic t_seq();
    @(negedge clk); dev_status = 4'hA;
    seq_pulse(5'b00010);
    rd(A_STA); chk(s_data, 32'h850A, "R12 bt set and dev bits");
    seq_pulse(5'b10000);
    rd(A_STA); chk(s_data, 32'h890A, "R12 kill");
  endtask

  task automatic t_wake();
    wr(A_CTL, 32'h1000_1000); chk(s_flush, 0, "R4 wake no flush");
    rd(A_STA); chk(s_data, 32'h9D0A, "R4 wake with run");
    seq_pulse(5'b00100);
    rd(A_STA); chk(s_data, 32'h8D0A, "R12 wake cleared");
    seq_pulse(5'b01000);
    rd(A_STA); chk(s_data, 32'h890A, "R12 stop");
  endtask

  task automatic t_stop();
    wr(A_CTL, 32'h8000_0000); chk(s_flush, 1, "R3 flush on run clear");
    rd(A_STA); chk(s_data, 32'h890A, "R3 old status during flush");
    ack();
    rd(A_STA); chk(s_data, 32'h010A, "R3 run dead active cleared");
    wr(A_CTL, 32'h1000_1000); chk(s_flush, 1, "R4 flush when stopped");
    ack();
    rd(A_STA); chk(s_data, 32'h010A, "R4 no wake without run");
  endtask

  task automatic t_flush();
    wr(A_CTL, 32'h8000_8000);
    rd(A_STA); chk(s_data, 32'h850A, "R2 rerun");
    wr(A_CTL, 32'h2000_2000); chk(s_flush, 1, "R6 flush requested");
    rd(A_CTL); chk(s_data, 32'hA50A, "R6 flush visible");
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = A_ISEL; bus_wdata = 32'hFFFF_FFFF;
    #1; chk({31'd0, bus_ready}, 0, "R6 writes stalled");
    bus_valid = 0; bus_write = 0;
    ack();
    chk({31'd0, flush_req}, 0, "R6 flush dropped");
    rd(A_CTL); chk(s_data, 32'h850A, "R6 flush bit gone");
    rd(A_ISEL); chk(s_data, 0, "R6 stalled write had no effect");
  endtask

  task automatic t_pause();
    wr(A_CTL, 32'h4000_4000); chk(s_flush, 1, "R5 flush on pause");
    ack();
    rd(A_STA); chk(s_data, 32'hC10A, "R5 paused inactive");
    wr(A_CTL, 32'h4000_0000); chk(s_kick, 1, "R5 kick on unpause");
    rd(A_STA); chk(s_data, 32'h850A, "R5 unpause active");
  endtask

  task automatic t_ptr();
    wr(A_CTL, 32'h8000_0000); ack();
    wr(A_PTR, 32'h1234_567F); chk(s_fetch, 1, "R8 fetch pulse");
    rd(A_PTR); chk(s_data, 32'h1234_5670, "R8 aligned pointer");
    @(negedge clk); seq_ptr_we = 1; seq_ptr = 32'hABCD_EF19;
    @(negedge clk); seq_ptr_we = 0;
    rd(A_PTR); chk(s_data, 32'hABCD_EF10, "R13 sequencer pointer load");
  endtask

  task automatic t_sel();
    wr(A_ISEL, 32'h000F_0005); wr(A_BSEL, 32'hDEAD_BEEF); wr(A_WSEL, 32'h1234_5678);
    rd(A_ISEL); chk(s_data, 32'h000F_0005, "R9 intr sel");
    rd(A_BSEL); chk(s_data, 32'hDEAD_BEEF, "R9 branch sel");
    rd(A_WSEL); chk(s_data, 32'h1234_5678, "R9 wait sel");
    wr(BASE + 12'h1C, 32'hFFFF_FFFF);
    rd(BASE + 12'h1C); chk(s_data, 0, "R9 unused word zero");
    rd(BASE + 12'h3C); chk(s_data, 0, "R9 last word zero");
  endtask

  task automatic t_size_and_decode();
    wr(A_PTR, 32'h5555_5550, 4'h3);
    rd(A_PTR); chk(s_data, 32'hABCD_EF10, "R10 partial write dropped");
    rd(A_ISEL, 4'h1); chk(s_data, 0, "R10 partial read zero");
    wr(12'h08C, 32'h0);
    rd(A_ISEL); chk(s_data, 32'h000F_0005, "R11 other channel write ignored");
    rd(12'h08C); chk({31'd0, s_valid}, 0, "R11 no response for other channel");
    seq_pulse(5'b00001);
    rd(A_STA); chk(s_data, 32'h000A, "R12 bt cleared");
  endtask

  initial begin
    #(200000 * 4);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_run();
    t_ptr_lock();
    t_seq();
    t_wake();
    t_stop();
    t_flush();
    t_pause();
    t_ptr();
    t_sel();
    t_size_and_decode();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule